// File: doc/BRIEF.md
# Serial BIST Instruction Loader

This block is the serial front end of a memory self-test engine. A tester shifts an instruction word in over one data pin while an instruction shift enable is high. Data trails the enable by one cycle, so the bit on the pin is taken in the cycle after the enable was seen high. The last bit is taken in the cycle after the enable falls.

An instruction may be followed straight away by an 8-bit go/no-go control field. During that part the datalog shift enable is also high. When shifting ends, the loader checks how many instruction bits it received. If the count is exactly 16, it presents the instruction fields and the go/no-go field in parallel and pulses a one-cycle load-done strobe. If the count is wrong, it raises an error flag and leaves the presented values alone.

Loading is accepted only while the test-mode enable is high and the engine is held in reset. Dropping the test-mode enable wipes all loaded state.

Top module: `bist_instr_loader`

## Requirements
- R1: After `rst_n` is asserted, every output is zero.
- R2: The instruction is 16 bits wide and shifted in LSB first. Output `mode` is bits [1:0], with 00 meaning manufacturing and 01 meaning bitmap. Output `algo` is bits [5:2]. Output `mask` is bits [15:6].
- R3: The bit on `sdata` is captured only in the cycle after `shift_en` was sampled high. The value on `sdata` in the cycle in which `shift_en` rises is never captured. The bit presented in the cycle after `shift_en` falls is the last bit captured.
- R4: `load_done` is high for exactly one cycle: the cycle after the edge that captures the final bit.
- R5: If a load ends with a count other than 16 instruction bits, `load_err` is set, `load_done` stays low, and `mode`, `algo`, `mask` and `gonogo` keep their previous values.
- R6: Bits captured while the delayed `dshift_en` is also high are a go/no-go field. They are shifted LSB first into an 8-bit register and do not count as instruction bits. A successful load presents that field on `gonogo`, or zero if the load carried no go/no-go bits.
- R7: While `engine_rst` is low, serial bits are ignored. No outputs change and `load_done` stays low.
- R8: While `test_en` is low, `mode`, `algo`, `mask`, `gonogo`, `load_err` and `load_done` are zero and serial bits are ignored.
- R9: A successful load clears `load_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | Test-mode enable; low clears all loaded state |
| engine_rst | input | 1 | High while the test engine is held in reset; loading is permitted only then |
| shift_en | input | 1 | Instruction shift enable |
| dshift_en | input | 1 | Datalog shift enable; high together with `shift_en` selects go/no-go bits |
| sdata | input | 1 | Serial data, one cycle behind the enables |
| mode | output | 2 | Test mode field (00 manufacturing, 01 bitmap) |
| algo | output | 4 | Algorithm select field |
| mask | output | 10 | Array enable mask |
| gonogo | output | 8 | Go/no-go control field |
| load_done | output | 1 | One-cycle strobe when a load completes with 16 instruction bits |
| load_err | output | 1 | Set by a load with the wrong bit count |

## Verification
The assertions assume that `test_en` stays steady across each load. They also assume that the presented fields change only through a completing load or a clear, so a drop of `test_en` is the only other event allowed to disturb them. The driver changes every input on the falling clock edge and holds `test_en` steady around each load. It releases the enables in the one-cycle-lagged order that the serial protocol needs. It leaves at least one idle cycle after every load before it starts the next.

// File: rtl/bist_instr_loader.sv
module bist_instr_loader #(
  parameter int IW     = 16,
  parameter int GW     = 8,
  parameter int MODE_W = 2,
  parameter int ALGO_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     test_en,
  input  logic                     engine_rst,
  input  logic                     shift_en,
  input  logic                     dshift_en,
  input  logic                     sdata,
  output logic [MODE_W-1:0]        mode,
  output logic [ALGO_W-1:0]        algo,
  output logic [IW-MODE_W-ALGO_W-1:0] mask,
  output logic [GW-1:0]            gonogo,
  output logic                     load_done,
  output logic                     load_err
);
  localparam int CW = $clog2(IW + 2);
  localparam logic [CW-1:0] FULL = CW'(IW);
  localparam logic [CW-1:0] SAT  = CW'(IW + 1);

  logic          sh_d, dsh_d, active;
  logic [CW-1:0] cnt;
  logic [IW-1:0] ishift, ireg;
  logic [GW-1:0] gshift, greg;

  wire permit  = test_en & engine_rst;
  wire capture = sh_d & permit;
  wire finish  = ~sh_d & active;

  assign mode   = ireg[MODE_W-1:0];
  assign algo   = ireg[MODE_W+ALGO_W-1:MODE_W];
  assign mask   = ireg[IW-1:MODE_W+ALGO_W];
  assign gonogo = greg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_d <= 1'b0; dsh_d <= 1'b0; active <= 1'b0; cnt <= '0;
      ishift <= '0; ireg <= '0; gshift <= '0; greg <= '0;
      load_done <= 1'b0; load_err <= 1'b0;
    end else if (!test_en) begin
      sh_d <= 1'b0; dsh_d <= 1'b0; active <= 1'b0; cnt <= '0;
      ishift <= '0; ireg <= '0; gshift <= '0; greg <= '0;
      load_done <= 1'b0; load_err <= 1'b0;
    end else begin
      sh_d      <= shift_en;
      dsh_d     <= dshift_en;
      load_done <= 1'b0;
      if (capture) begin
        active <= 1'b1;
        if (dsh_d) begin
          gshift <= {sdata, gshift[GW-1:1]};
        end else begin
          ishift <= {sdata, ishift[IW-1:1]};
          if (cnt != SAT) cnt <= cnt + 1'b1;
        end
      end else if (finish) begin
        active <= 1'b0;
        cnt    <= '0;
        ishift <= '0;
        gshift <= '0;
        if (cnt == FULL) begin
          ireg      <= ishift;
          greg      <= gshift;
          load_done <= 1'b1;
          load_err  <= 1'b0;
        end else begin
          load_err  <= 1'b1;
        end
      end
    end
  end
endmodule

module bist_instr_loader_chk #(
  parameter int IW = 16,
  parameter int GW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          test_en,
  input logic [IW-1:0] fields,
  input logic [GW-1:0] gonogo,
  input logic          load_done,
  input logic          load_err
);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done);

  a_r5_done_excludes_err: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> !load_err);

  a_r5_err_rise_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_err) |-> !load_done);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |=> (fields == '0 && gonogo == '0 && !load_err && !load_done));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && $past(test_en) && !load_done) |-> $stable({fields, gonogo}));

  a_r9_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> !load_err);
endmodule

bind bist_instr_loader bist_instr_loader_chk #(.IW(IW), .GW(GW)) chk_i (
  .clk(clk), .rst_n(rst_n), .test_en(test_en),
  .fields({mask, algo, mode}), .gonogo(gonogo),
  .load_done(load_done), .load_err(load_err)
);

// File: tb/bist_instr_loader_tb.sv
module bist_instr_loader_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0, test_en = 1'b0, engine_rst = 1'b0;
  logic shift_en = 1'b0, dshift_en = 1'b0, sdata = 1'b0;
  logic [1:0] mode; logic [3:0] algo; logic [9:0] mask;
  logic [7:0] gonogo; logic load_done, load_err;

  always #10 clk = ~clk;

  bist_instr_loader dut_i (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .engine_rst(engine_rst),
    .shift_en(shift_en), .dshift_en(dshift_en), .sdata(sdata),
    .mode(mode), .algo(algo), .mask(mask), .gonogo(gonogo),
    .load_done(load_done), .load_err(load_err));

  typedef struct packed { logic ok; logic [15:0] ins; logic [7:0] g; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  logic [15:0] cur_i = '0;
  logic [7:0]  cur_g = '0;
  logic prev_err = 1'b0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && test_en) begin
      if (load_done || (load_err && !prev_err)) begin
        if (q.size() == 0) begin
          chk("R7 unexpected completion event", {load_done, load_err}, 32'h0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk("R5 completion kind", {31'b0, load_done}, {31'b0, e.ok});
          chk("R2 instruction word", {16'b0, mask, algo, mode}, {16'b0, e.ins});
          chk("R6 go/no-go field", {24'b0, gonogo}, {24'b0, e.g});
        end
      end
    end
    prev_err = load_err;
  end

  task automatic run_load(input logic [31:0] ib, input int ni, input logic [7:0] gb,
                          input int ng, input bit counted);
    int total;
    logic [15:0] ri;
    logic [7:0]  rg;
    total = ni + ng;
    ri = '0; rg = '0;
    for (int j = 0; j < ni; j++) ri = {ib[j], ri[15:1]};
    for (int j = 0; j < ng; j++) rg = {gb[j], rg[7:1]};
    @(negedge clk);
    shift_en = 1'b1; dshift_en = (ni == 0 && ng > 0); sdata = ~ib[0];
    for (int k = 0; k < total; k++) begin
      @(negedge clk);
      sdata = (k < ni) ? ib[k] : gb[k-ni];
      shift_en = (k < total - 1);
      dshift_en = (k + 1 < total) && (k + 1 >= ni);
    end
    if (counted) begin
      if (ni == 16) begin cur_i = ri; cur_g = rg; q.push_back('{1'b1, cur_i, cur_g}); end
      else q.push_back('{1'b0, cur_i, cur_g});
    end
    @(negedge clk); sdata = ~sdata;
    chk("R4 no strobe at capture edge", {31'b0, load_done}, 32'h0);
    @(negedge clk);
    if (counted && ni == 16) begin
      chk("R4 strobe one cycle after last capture", {31'b0, load_done}, 32'h1);
      chk("R9 error cleared by good load", {31'b0, load_err}, 32'h0);
    end else if (counted) begin
      chk("R5 error flag set", {31'b0, load_err}, 32'h1);
      chk("R5 no strobe on bad count", {31'b0, load_done}, 32'h0);
    end
    @(negedge clk);
    chk("R4 strobe lasts one cycle", {31'b0, load_done}, 32'h0);
  endtask

  bit finished = 1'b0;

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset fields", {16'b0, mask, algo, mode}, 32'h0);
    chk("R1 reset flags", {22'b0, gonogo, load_done, load_err}, 32'h0);
    rst_n = 1'b1; test_en = 1'b1; engine_rst = 1'b1;
    @(negedge clk);

    run_load(32'h0000_5A3D, 16, 8'h00, 0, 1'b1);
    chk("R2 mode field", {30'b0, mode}, 32'h1);
    chk("R2 algo field", {28'b0, algo}, 32'hF);
    chk("R2 mask field", {22'b0, mask}, {22'b0, 10'h168});
    chk("R6 zero go/no-go when absent", {24'b0, gonogo}, 32'h0);

    run_load(32'h0000_C0F1, 16, 8'hA5, 8, 1'b1);
    chk("R6 go/no-go presented", {24'b0, gonogo}, 32'hA5);
    chk("R3 lagged capture word", {16'b0, mask, algo, mode}, 32'hC0F1);

    run_load(32'h0000_1234, 15, 8'h00, 0, 1'b1);
    chk("R5 fields held", {16'b0, mask, algo, mode}, 32'hC0F1);
    chk("R5 go/no-go held", {24'b0, gonogo}, 32'hA5);

    run_load(32'h0000_8002, 16, 8'h3C, 8, 1'b1);
    chk("R9 err low after good load", {31'b0, load_err}, 32'h0);

    run_load(32'h0001_FFFF, 17, 8'h00, 0, 1'b1);
    chk("R5 long load flagged", {31'b0, load_err}, 32'h1);

    engine_rst = 1'b0;
    run_load(32'h0000_7777, 16, 8'h11, 8, 1'b0);
    chk("R7 fields unchanged", {16'b0, mask, algo, mode}, 32'h8002);
    chk("R7 go/no-go unchanged", {24'b0, gonogo}, 32'h3C);
    engine_rst = 1'b1;
    @(negedge clk);

    test_en = 1'b0;
    @(negedge clk);
    chk("R8 fields cleared", {16'b0, mask, algo, mode}, 32'h0);
    chk("R8 flags cleared", {22'b0, gonogo, load_done, load_err}, 32'h0);
    run_load(32'h0000_ABCD, 16, 8'h00, 0, 1'b0);
    chk("R8 loads ignored while disabled", {16'b0, mask, algo, mode}, 32'h0);
    test_en = 1'b1;
    cur_i = '0; cur_g = '0;
    @(negedge clk);

    run_load(32'h0000_FFC0, 16, 8'h01, 8, 1'b1);
    run_load(32'h0000_0001, 16, 8'h80, 8, 1'b1);
    chk("R6 go/no-go msb", {24'b0, gonogo}, 32'h80);

    repeat (3) @(negedge clk);
    chk("R4 all expected events seen", q.size(), 32'h0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule